// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases one block of a byte-wide parallel NAND flash for a host. The host hands over an 11-bit block number with a valid/ready handshake. The sequencer then drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines and the 8-bit data bus. It sends the erase setup command, two address bytes and the erase confirm command. After that it switches the device into status mode and keeps reading the status byte until the device reports ready, or until a timeout expires.

When the device reports ready, the status byte is turned into a 2-bit result code: ok, fail or write-protected. The sequencer then writes the plain read command, so that the device leaves status mode before any later page access. If the timeout runs out first, the result is a timeout code and no further command is written. The widths of the strobe phases and the timeout are parameters counted in clock cycles, so the same block can run at different clock rates.

Top module: `eraseSequencer`

## Requirements
- R1: While reset is held, ceN, weN and reN are 1, cle, ale, ioOe and doneValid are 0, and reqReady follows rdyBusy.
- R2: reqReady is 1 only while the sequencer is idle and rdyBusy is 1. A request is taken on a clock edge where reqValid and reqReady are both 1. With rdyBusy at 0, a pending request starts no bus activity.
- R3: Each byte is latched on a rising edge of weN. The bytes of one erase come in this order: 60h with cle=1, two address bytes with ale=1, D0h with cle=1, then 70h with cle=1.
- R4: The first address byte is {reqRow[2:0], 5'b00000} and the second is reqRow[10:3]. The low five page bits are always zero.
- R5: Each weN low pulse lasts exactly WE_LOW cycles. ioOut, cle and ale hold steady while weN is low.
- R6: After 70h, the status byte is read by pulsing reN low. No further command is written until status bit 6 reads 1 or the timeout fires.
- R7: With bit 6 = 1, the result is decided by bits 7 and 0. Bit 7 = 0 gives code 2 (protected), whatever bit 0 holds. Otherwise bit 0 = 1 gives code 1 (fail) and bit 0 = 0 gives code 0 (ok).
- R8: If bit 6 has not read 1 by the end of a read cycle at least TIMEOUT_CYC cycles after the rising weN edge of D0h, the result is code 3 (timeout) and no 00h is written.
- R9: For every result other than timeout, command 00h with cle=1 is written after the last status read and before doneValid.
- R10: doneValid is a single-cycle pulse carrying doneCode, and ceN is 1 in that cycle.
- R11: cle and ale are never 1 together, and weN and reN are never 0 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Erase request present |
| reqReady | output | 1 | Request can be taken |
| reqRow | input | 11 | Block number to erase |
| doneValid | output | 1 | One-cycle completion pulse |
| doneCode | output | 2 | 0 ok, 1 fail, 2 protected, 3 timeout |
| ceN | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Bus byte driven to the device |
| ioOe | output | 1 | Bus drive enable |
| ioIn | input | 8 | Bus byte from the device |
| rdyBusy | input | 1 | Device ready (1) or busy (0) |

## Verification
The bench targets the precedence among the status bits. It uses a protected device that also sets bit 0, which a design giving bit 0 priority would report as a failure. It also varies the busy time so that several status reads return bit 6 at 0, which exposes a design that samples bit 0 too early and reports ok while the device is still erasing. A device that stays busy past the timeout checks that a timeout still writes no 00h, and that reqReady stays low until the device is ready again. Address bytes are checked against random block numbers, which catches a wrong bit split or non-zero page bits.

// File: rtl/eraseSeqPkg.sv
package eraseSeqPkg;
  localparam int BLK_ADDR_W = 11;

  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_READ    = 8'h00;

  typedef enum logic [1:0] {OP_NONE, OP_CMD, OP_ADR, OP_READ} busOp_e;
  typedef enum logic [2:0] {SEL_SETUP, SEL_ADR_LO, SEL_ADR_HI, SEL_CONFIRM, SEL_STATUS, SEL_READ} byteSel_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_FAIL = 2'd1, RES_PROT = 2'd2, RES_TIMEOUT = 2'd3} result_e;

  typedef struct packed {
    logic     loadRow;
    busOp_e   op;
    byteSel_e sel;
    logic     armTimer;
  } strobe_t;
endpackage

// File: rtl/eraseDatapath.sv
module eraseDatapath
  import eraseSeqPkg::*;
#(
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int RD_LOW      = 2,
  parameter int RD_HIGH     = 2,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [BLK_ADDR_W-1:0] reqRow,
  input  logic [7:0]            ioIn,
  output logic                  phaseEnd,
  output logic                  stsReady,
  output logic                  stsFail,
  output logic                  stsUnprot,
  output logic                  timedOut,
  output logic                  ceN,
  output logic                  cle,
  output logic                  ale,
  output logic                  weN,
  output logic                  reN,
  output logic [7:0]            ioOut,
  output logic                  ioOe
);
  localparam int WR_TOT = WE_LOW + WE_HIGH;
  localparam int RD_TOT = RD_LOW + RD_HIGH;
  localparam int MAX_TOT = (WR_TOT > RD_TOT) ? WR_TOT : RD_TOT;
  localparam int CNT_W = $clog2(MAX_TOT + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 2);
  localparam logic [CNT_W-1:0] WE_LOW_C  = CNT_W'(WE_LOW);
  localparam logic [CNT_W-1:0] RD_LOW_C  = CNT_W'(RD_LOW);
  localparam logic [CNT_W-1:0] WR_LAST_C = CNT_W'(WR_TOT - 1);
  localparam logic [CNT_W-1:0] RD_LAST_C = CNT_W'(RD_TOT - 1);
  localparam logic [CNT_W-1:0] RD_SMP_C  = CNT_W'(RD_LOW - 1);
  localparam logic [TMR_W-1:0] TMO_C     = TMR_W'(TIMEOUT_CYC);

  logic [BLK_ADDR_W-1:0] rowReg;
  logic [CNT_W-1:0]      phaseCnt;
  logic [TMR_W-1:0]      eraseTmr;
  logic                  isWrite;
  logic                  unusedStatusBits;

  assign isWrite = (stb.op == OP_CMD) || (stb.op == OP_ADR);
  assign phaseEnd = isWrite ? (phaseCnt == WR_LAST_C)
                  : (stb.op == OP_READ) ? (phaseCnt == RD_LAST_C) : 1'b0;
  assign unusedStatusBits = ^ioIn[5:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg    <= '0;
      phaseCnt  <= '0;
      eraseTmr  <= '0;
      stsReady  <= 1'b0;
      stsFail   <= 1'b0;
      stsUnprot <= 1'b0;
    end else begin
      if (stb.loadRow) rowReg <= reqRow;
      if (stb.op == OP_NONE || phaseEnd) phaseCnt <= '0;
      else phaseCnt <= phaseCnt + 1'b1;
      if (stb.op == OP_READ && phaseCnt == RD_SMP_C) begin
        stsReady  <= ioIn[6];
        stsFail   <= ioIn[0];
        stsUnprot <= ioIn[7];
      end
      // erase time counts from the cycle the confirm strobe goes high
      if (stb.armTimer && phaseCnt < WE_LOW_C) eraseTmr <= '0;
      else if (eraseTmr <= TMO_C) eraseTmr <= eraseTmr + 1'b1;
    end
  end

  assign timedOut = (eraseTmr >= TMO_C);

  always_comb begin
    ceN   = (stb.op == OP_NONE);
    cle   = (stb.op == OP_CMD);
    ale   = (stb.op == OP_ADR);
    ioOe  = isWrite;
    weN   = !(isWrite && phaseCnt < WE_LOW_C);
    reN   = !(stb.op == OP_READ && phaseCnt < RD_LOW_C);
    case (stb.sel)
      SEL_SETUP:   ioOut = CMD_SETUP;
      SEL_ADR_LO:  ioOut = {rowReg[2:0], 5'b00000};
      SEL_ADR_HI:  ioOut = rowReg[10:3];
      SEL_CONFIRM: ioOut = CMD_CONFIRM;
      SEL_STATUS:  ioOut = CMD_STATUS;
      default:     ioOut = CMD_READ;
    endcase
  end
endmodule

// File: rtl/eraseCtrl.sv
module eraseCtrl
  import eraseSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rdyBusy,
  input  logic       phaseEnd,
  input  logic       stsReady,
  input  logic       stsFail,
  input  logic       stsUnprot,
  input  logic       timedOut,
  output logic       reqReady,
  output logic       doneValid,
  output logic [1:0] doneCode,
  output strobe_t    stb
);
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADR_LO, S_ADR_HI, S_CONFIRM, S_STATUS, S_POLL, S_READ, S_DONE
  } state_e;

  state_e  state, nextState;
  result_e code, nextCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      code  <= RES_OK;
    end else begin
      state <= nextState;
      code  <= nextCode;
    end
  end

  always_comb begin
    nextState = state;
    nextCode  = code;
    stb       = '{loadRow: 1'b0, op: OP_NONE, sel: SEL_READ, armTimer: 1'b0};
    reqReady  = 1'b0;
    doneValid = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = rdyBusy;
        if (reqValid && rdyBusy) begin
          stb.loadRow = 1'b1;
          nextState   = S_SETUP;
        end
      end
      S_SETUP: begin
        stb.op = OP_CMD; stb.sel = SEL_SETUP;
        if (phaseEnd) nextState = S_ADR_LO;
      end
      S_ADR_LO: begin
        stb.op = OP_ADR; stb.sel = SEL_ADR_LO;
        if (phaseEnd) nextState = S_ADR_HI;
      end
      S_ADR_HI: begin
        stb.op = OP_ADR; stb.sel = SEL_ADR_HI;
        if (phaseEnd) nextState = S_CONFIRM;
      end
      S_CONFIRM: begin
        stb.op = OP_CMD; stb.sel = SEL_CONFIRM; stb.armTimer = 1'b1;
        if (phaseEnd) nextState = S_STATUS;
      end
      S_STATUS: begin
        stb.op = OP_CMD; stb.sel = SEL_STATUS;
        if (phaseEnd) nextState = S_POLL;
      end
      S_POLL: begin
        stb.op = OP_READ;
        if (phaseEnd) begin
          if (stsReady) begin
            nextState = S_READ;
            if (!stsUnprot)   nextCode = RES_PROT;
            else if (stsFail) nextCode = RES_FAIL;
            else              nextCode = RES_OK;
          end else if (timedOut) begin
            nextState = S_DONE;
            nextCode  = RES_TIMEOUT;
          end
        end
      end
      S_READ: begin
        stb.op = OP_CMD; stb.sel = SEL_READ;
        if (phaseEnd) nextState = S_DONE;
      end
      S_DONE: begin
        doneValid = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign doneCode = code;
endmodule

// File: rtl/eraseSequencer.sv
module eraseSequencer
  import eraseSeqPkg::*;
#(
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int RD_LOW      = 2,
  parameter int RD_HIGH     = 2,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [10:0] reqRow,
  output logic        doneValid,
  output logic [1:0]  doneCode,
  output logic        ceN,
  output logic        cle,
  output logic        ale,
  output logic        weN,
  output logic        reN,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  input  logic [7:0]  ioIn,
  input  logic        rdyBusy
);
  strobe_t stb;
  logic phaseEnd, stsReady, stsFail, stsUnprot, timedOut;

  eraseCtrl ctrl_i (
    .clk, .rstN, .reqValid, .rdyBusy, .phaseEnd, .stsReady, .stsFail,
    .stsUnprot, .timedOut, .reqReady, .doneValid, .doneCode, .stb
  );

  eraseDatapath #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dp_i (
    .clk, .rstN, .stb, .reqRow, .ioIn, .phaseEnd, .stsReady, .stsFail,
    .stsUnprot, .timedOut, .ceN, .cle, .ale, .weN, .reN, .ioOut, .ioOe
  );
endmodule

// File: rtl/eraseSequencerChk.sv
module eraseSequencerChk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       doneValid,
  input logic       ceN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic [7:0] ioOut,
  input logic       rdyBusy
);
  p_latch_excl_r11: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !reN));
  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> rdyBusy);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> !reqReady);
  p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && $past(!weN)) |-> ($stable(ioOut) && $stable(cle) && $stable(ale)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN) doneValid |=> !doneValid);
  p_done_ce_r10: assert property (@(posedge clk) disable iff (!rstN) doneValid |-> ceN);
endmodule

bind eraseSequencer eraseSequencerChk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .doneValid(doneValid), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
  .reN(reN), .ioOut(ioOut), .rdyBusy(rdyBusy)
);

// File: tb/eraseSequencer_tb_top.sv
`timescale 1ns/1ps
module eraseSequencer_tb_top;
  localparam int WE_LOW = 2, WE_HIGH = 2, RD_LOW = 2, RD_HIGH = 2, TMO = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [10:0] reqRow = '0;
  logic reqReady, doneValid, ceN, cle, ale, weN, reN, ioOe, rdyBusy;
  logic [1:0] doneCode;
  logic [7:0] ioOut, ioIn;

  always #2.5 clk = ~clk;

  eraseSequencer #(.WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_LOW(RD_LOW),
                   .RD_HIGH(RD_HIGH), .TIMEOUT_CYC(TMO)) dut_i (
    .clk, .rstN, .reqValid, .reqReady, .reqRow, .doneValid, .doneCode,
    .ceN, .cle, .ale, .weN, .reN, .ioOut, .ioOe, .ioIn, .rdyBusy
  );

  int nChecks = 0, nFails = 0;
  int busyCnt = 0, busyLen = 0;
  logic rbOverride = 1'b0, protF = 1'b0, failF = 1'b0;
  logic [7:0] logByte [0:15];
  int logKind [0:15];
  int logN = 0, readPulses = 0, weLow = 0;
  logic prevWeN = 1'b1, prevReN = 1'b1, doneSeen = 1'b0;
  logic [1:0] seenCode = '0;

  assign rdyBusy = !rbOverride && (busyCnt == 0);
  assign ioIn = {!protF, busyCnt == 0, 5'b00000, failF};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expCode(input bit prot, input bit fail, input bit tmo);
    if (tmo) return 2'd3;
    if (prot) return 2'd2;
    return fail ? 2'd1 : 2'd0;
  endfunction

  // device model and bus monitor, all on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (!weN) weLow++;
      if (weN && !prevWeN) begin
        check(weLow == WE_LOW, "R5 weN low width", weLow, WE_LOW);
        if (logN < 16) begin
          logByte[logN] = ioOut;
          logKind[logN] = cle ? 1 : (ale ? 2 : 0);
          logN++;
        end
        if (cle && ioOut == 8'hD0) busyCnt = busyLen;
        weLow = 0;
      end
      if (!reN && prevReN) readPulses++;
      if (doneValid) begin
        doneSeen = 1'b1;
        seenCode = doneCode;
        check(ceN == 1'b1, "R10 ceN high at done", ceN, 1);
      end
      if (busyCnt > 0) busyCnt--;
    end
    prevWeN = weN;
    prevReN = reN;
  end

  task automatic expectByte(input int idx, input logic [7:0] b, input int kind, input string req);
    check(idx < logN && logByte[idx] == b && logKind[idx] == kind, req,
          (idx < logN) ? int'(logByte[idx]) : -1, b);
  endtask

  task automatic runErase(input logic [10:0] row, input int busy, input bit prot, input bit fail);
    int waitCnt;
    bit tmo;
    tmo = (busy > TMO);
    protF = prot; failF = fail; busyLen = busy;
    waitCnt = 0;
    @(negedge clk);
    while (!reqReady && waitCnt < 5000) begin @(negedge clk); waitCnt++; end
    logN = 0; readPulses = 0; doneSeen = 1'b0;
    reqValid = 1'b1; reqRow = row;
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt = 0;
    while (!doneSeen && waitCnt < 5000) begin @(negedge clk); waitCnt++; end
    check(doneSeen, "R10 done seen", doneSeen, 1);
    check(seenCode == expCode(prot, fail, tmo), "R7 R8 result code", seenCode, expCode(prot, fail, tmo));
    expectByte(0, 8'h60, 1, "R3 setup");
    expectByte(1, {row[2:0], 5'b00000}, 2, "R4 address low");
    expectByte(2, row[10:3], 2, "R4 address high");
    expectByte(3, 8'hD0, 1, "R3 confirm");
    expectByte(4, 8'h70, 1, "R3 status cmd");
    check(readPulses >= 1, "R6 status reads", readPulses, 1);
    if (tmo) begin
      check(logN == 5, "R8 no read cmd after timeout", logN, 5);
      check(reqReady == 1'b0, "R2 not ready while device busy", reqReady, 0);
    end else begin
      check(logN == 6, "R9 write count", logN, 6);
      expectByte(5, 8'h00, 1, "R9 read cmd");
      check(readPulses >= busy / (RD_LOW + RD_HIGH) - 2, "R6 polled through busy", readPulses, busy / 4);
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(ceN && weN && reN && !cle && !ale && !ioOe && !doneValid, "R1 reset outputs",
          {ceN, weN, reN, cle, ale, ioOe, doneValid}, 7'b1110000);
    check(reqReady == rdyBusy, "R1 ready in reset", reqReady, rdyBusy);
    rstN = 1'b1;
    // R2: request held off while busy line is low
    rbOverride = 1'b1; reqValid = 1'b1; reqRow = 11'h123;
    repeat (8) begin
      @(negedge clk);
      check(!reqReady && ceN && weN, "R2 held while busy", {reqReady, ceN, weN}, 3'b011);
    end
    reqValid = 1'b0; rbOverride = 1'b0;
    runErase(11'h7FF, 30, 1'b0, 1'b0);
    runErase(11'h001, 45, 1'b0, 1'b1);
    runErase(11'h2AA, 60, 1'b1, 1'b0);
    runErase(11'h555, 20, 1'b1, 1'b1);
    runErase(11'h000, 3, 1'b0, 1'b0);
    runErase(11'h155, 700, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      int b;
      b = 10 + int'($urandom % 280);
      if ($urandom % 8 == 0) b = 650;
      runErase(11'($urandom), b, ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule